// File: doc/BRIEF.md
# Serial Transmitter with Break and Idle Preamble

This block shifts asynchronous serial frames onto a single output line. A byte (or a 9-bit word in the long format) is written into a holding register. At the next frame boundary it moves into the shift register and goes out as a start bit, the data bits least significant first, and a stop bit. Every bit lasts a fixed number of baud ticks. The ticks come from an external rate divider, which sits outside this block.

Two control bits steer the line. The enable bit gives the transmitter ownership of the line, and each rising edge of it queues one frame time of mark level as a preamble. The break bit asks for frames of all zeros. A break request has priority over the preamble and over pending data. The block never cuts a frame short: enable removal, break release and break pulses all take effect only at a frame boundary. A short pulse of the break bit, marked by the break-write event, therefore still produces exactly one whole break frame.

Top module: `uart_tx_brk`

## Requirements
- R1: After reset, `txd` is 1, `tdre` is 1 and `tc` is 1.
- R2: A data frame is a 0 start bit, then data sent LSB first, then a 1 stop bit. With `long_fmt`=0 the data is `wr_data[7:0]` and bit 8 is not sent. With `long_fmt`=1 the data is `wr_data[8:0]`.
- R3: Each bit on `txd` lasts exactly 16 `baud_tick` pulses, and the line does not advance on cycles without a tick.
- R4: `tdre` is 0 in the cycle after a write and returns to 1 when the word enters the shift register. `tc` is 0 while any word, preamble or break is pending or in flight, and is 1 once all of them are done.
- R5: A rising edge of `tx_en` queues one preamble of ones, lasting one frame time (10 bits short, 11 bits long), before the next data frame.
- R6: While `tx_en` is 0 no frame starts, `txd` stays 1, and a written word stays held with `tdre` at 0.
- R7: Clearing `tx_en` during a frame lets that frame finish intact, and then `txd` stays 1.
- R8: While `brk_req` is held, break frames of zeros follow back to back. After release, the frame in progress completes, so the zero run is a whole number of frame times.
- R9: A `brk_wr` pulse with `brk_req` dropped before the frame ends sends exactly one break frame (160 ticks short, 176 long), then the line returns to 1.
- R10: At a frame boundary, a pending break is sent before a pending data word. The word then follows directly after the break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 9 | Word to send (bit 8 is used in the long format only) |
| long_fmt | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| tx_en | input | 1 | Transmitter enable; a rising edge queues a preamble |
| brk_req | input | 1 | Level request for break frames |
| brk_wr | input | 1 | Pulse marking a write of the break bit |
| txd | output | 1 | Serial output line, idle high |
| tdre | output | 1 | Holding register empty |
| tc | output | 1 | Transmission complete |

## Verification
The bench targets the following faults:
- A preamble skipped when data is written in the same cycle as the enable. A design with this fault shows a start bit about 160 cycles too early.
- A break pulse that is too short to be sampled at a frame boundary. A design with this fault either sends no zeros or sends a run shorter than one frame.
- A held break released in mid-frame. A design with this fault truncates the zero run instead of rounding it up to whole frames.
- A frame cut short when the enable drops. A design with this fault returns a corrupted word or a missing stop bit.

A break and a data word requested in the same cycle must produce a single zero run of one frame plus one start bit. The word must then decode correctly. Random words in both formats and a slower tick rate show whether bits are dropped, shifted or given the wrong width.

// File: rtl/utx_pkg.sv
package utx_pkg;

  typedef enum logic [1:0] {
    UTX_IDLE,
    UTX_PRE,
    UTX_DATA,
    UTX_BRK
  } utx_state_e;

  // Frame length in bits: start + data + stop, data_w bits in long format,
  // one fewer in short format.
  function automatic int frame_len(input logic long_fmt, input int data_w);
    return long_fmt ? (data_w + 2) : (data_w + 1);
  endfunction

endpackage

// File: rtl/utx_bitclk.sv
module utx_bitclk #(
  parameter int TICKS_PER_BIT = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             start,
  input  logic [IDX_W-1:0] nbits,
  output logic             bit_end,
  output logic             frame_end
);
  localparam int SUB_W = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(TICKS_PER_BIT - 1);

  logic [SUB_W-1:0] sub_q;
  logic [IDX_W-1:0] idx_q;

  assign bit_end   = run && tick && (sub_q == SUB_LAST);
  assign frame_end = bit_end && (idx_q == (nbits - 1'b1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q <= '0;
      idx_q <= '0;
    end else if (start) begin
      sub_q <= '0;
      idx_q <= '0;
    end else if (run && tick) begin
      if (sub_q == SUB_LAST) begin
        sub_q <= '0;
        idx_q <= idx_q + 1'b1;
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end

  // R3: the bit timer moves only on baud ticks
  assert_hold_without_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick && !start) |=> $stable(sub_q));

endmodule

// File: rtl/utx_holdreg.sv
module utx_holdreg #(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic [DATA_W-1:0] hold_data,
  output logic              tdre
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_data <= '0;
      tdre      <= 1'b1;
    end else if (wr_en) begin
      hold_data <= wr_data;
      tdre      <= 1'b0;
    end else if (take) begin
      tdre      <= 1'b1;
    end
  end

  // R4: a word is only moved out of a full holding register
  assert_take_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !tdre);

  // R4: a write empties the flag on the next cycle
  assert_write_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !tdre);

endmodule

// File: rtl/utx_seq.sv
module utx_seq
  import utx_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int IDX_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              tx_en,
  input  logic              brk_req,
  input  logic              brk_wr,
  input  logic              long_fmt,
  input  logic              tdre,
  input  logic [DATA_W-1:0] hold_data,
  input  logic              bit_end,
  input  logic              frame_end,
  output logic              txd,
  output logic              take,
  output logic              start,
  output logic              run,
  output logic [IDX_W-1:0]  nbits,
  output logic              tc
);
  localparam int FRAME_W = DATA_W + 2;

  utx_state_e         state_q, nxt;
  logic               en_q, pre_pend, brk_pend;
  logic [FRAME_W-1:0] shreg;
  logic               en_rise, pre_want, brk_want, decide;

  // Line pattern, LSB goes out first: start 0, data, stop 1, padding 1.
  function automatic logic [FRAME_W-1:0] pattern(input logic [DATA_W-1:0] d,
                                                  input logic lf);
    logic [FRAME_W-1:0] p;
    p    = '1;
    p[0] = 1'b0;
    if (lf) p[DATA_W:1] = d;
    else    p[DATA_W-1:1] = d[DATA_W-2:0];
    return p;
  endfunction

  assign en_rise  = tx_en && !en_q;
  assign pre_want = pre_pend || en_rise;
  assign brk_want = brk_pend || brk_req || brk_wr;
  assign decide   = ((state_q == UTX_IDLE) && tick) || frame_end;

  always_comb begin
    nxt = UTX_IDLE;
    if (!tx_en)        nxt = UTX_IDLE;
    else if (brk_want) nxt = UTX_BRK;
    else if (pre_want) nxt = UTX_PRE;
    else if (!tdre)    nxt = UTX_DATA;
  end

  assign start = decide && (nxt != UTX_IDLE);
  assign take  = decide && (nxt == UTX_DATA);
  assign run   = (state_q != UTX_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= UTX_IDLE;
      en_q     <= 1'b0;
      pre_pend <= 1'b0;
      brk_pend <= 1'b0;
      shreg    <= '1;
      nbits    <= IDX_W'(frame_len(1'b0, DATA_W));
    end else begin
      en_q <= tx_en;

      if (!tx_en)                        pre_pend <= 1'b0;
      else if (decide && nxt == UTX_PRE) pre_pend <= 1'b0;
      else if (en_rise)                  pre_pend <= 1'b1;

      if (!tx_en)                        brk_pend <= 1'b0;
      else if (decide && nxt == UTX_BRK) brk_pend <= 1'b0;
      else if (brk_wr)                   brk_pend <= 1'b1;

      if (decide) state_q <= nxt;
      if (start)  nbits   <= IDX_W'(frame_len(long_fmt, DATA_W));

      if (take)
        shreg <= pattern(hold_data, long_fmt);
      else if (bit_end && state_q == UTX_DATA)
        shreg <= {1'b1, shreg[FRAME_W-1:1]};
    end
  end

  always_comb begin
    unique case (state_q)
      UTX_BRK:  txd = 1'b0;
      UTX_DATA: txd = shreg[0];
      default:  txd = 1'b1;
    endcase
  end

  assign tc = (state_q == UTX_IDLE) && tdre &&
              !(tx_en && (pre_want || brk_want));

  // R7: a frame, once started, keeps its kind until the timer ends it
  assert_frame_runs_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !frame_end) |=> (state_q == $past(state_q)));

  // R6: a frame ending with the enable low leaves the line idle
  assert_disable_idles_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !tx_en) |=> (state_q == UTX_IDLE));

  // R8: a held break request chains another break frame
  assert_break_chains_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && tx_en && brk_req) |=> (state_q == UTX_BRK));

  // R9: with nothing requesting more, a break frame is not repeated
  assert_brief_break_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && state_q == UTX_BRK && !brk_req && !brk_pend && !brk_wr)
      |=> (state_q != UTX_BRK));

endmodule

// File: rtl/uart_tx_brk.sv
module uart_tx_brk #(
  parameter int TICKS_PER_BIT = 16,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              long_fmt,
  input  logic              tx_en,
  input  logic              brk_req,
  input  logic              brk_wr,
  output logic              txd,
  output logic              tdre,
  output logic              tc
);
  localparam int IDX_W = $clog2(DATA_W + 3);

  logic [DATA_W-1:0] hold_data;
  logic              take, start, run, bit_end, frame_end;
  logic [IDX_W-1:0]  nbits;

  utx_holdreg #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .take(take), .hold_data(hold_data), .tdre(tdre)
  );

  utx_bitclk #(.TICKS_PER_BIT(TICKS_PER_BIT), .IDX_W(IDX_W)) u_bclk (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .run(run), .start(start),
    .nbits(nbits), .bit_end(bit_end), .frame_end(frame_end)
  );

  utx_seq #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .tx_en(tx_en),
    .brk_req(brk_req), .brk_wr(brk_wr), .long_fmt(long_fmt), .tdre(tdre),
    .hold_data(hold_data), .bit_end(bit_end), .frame_end(frame_end),
    .txd(txd), .take(take), .start(start), .run(run), .nbits(nbits), .tc(tc)
  );

endmodule

// File: tb/sim_uart_tx_brk.sv
module sim_uart_tx_brk;
  logic       clk = 1'b0, rst_n = 1'b0, baud_tick = 1'b0, wr_en = 1'b0;
  logic       long_fmt = 1'b0, tx_en = 1'b0, brk_req = 1'b0, brk_wr = 1'b0;
  logic [8:0] wr_data = '0;
  wire        txd, tdre, tc;

  int  checks = 0, errors = 0, cpt = 1, ph = 0;
  bit  done = 1'b0;

  uart_tx_brk u0 (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en),
    .wr_data(wr_data), .long_fmt(long_fmt), .tx_en(tx_en), .brk_req(brk_req),
    .brk_wr(brk_wr), .txd(txd), .tdre(tdre), .tc(tc)
  );

  always #2 clk = ~clk;

  initial forever begin
    @(negedge clk);
    baud_tick = (ph == 0);
    ph = (ph + 1 >= cpt) ? 0 : ph + 1;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic nclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [8:0] expect_word(input logic [8:0] d, input bit lf);
    return lf ? d : {1'b0, d[7:0]};
  endfunction

  function automatic int frame_ticks(input bit lf);
    return lf ? 11 * 16 : 10 * 16;
  endfunction

  task automatic wait_low(output int waited, input int limit);
    waited = 0;
    @(negedge clk);
    while (txd !== 1'b0 && waited < limit) begin
      waited++;
      @(negedge clk);
    end
  endtask

  task automatic low_run(output int len);
    len = 0;
    while (txd === 1'b0 && len < 20000) begin
      len++;
      @(negedge clk);
    end
  endtask

  task automatic rx_bits(input bit lf, input bit at_bit0, input int already,
                         output logic [8:0] d, output bit stop);
    int nb = lf ? 9 : 8;
    nclk((at_bit0 ? 8 : 24) * cpt - already);
    d = '0;
    for (int i = 0; i < nb; i++) begin
      d[i] = txd;
      if (i < nb - 1) nclk(16 * cpt);
    end
    nclk(16 * cpt);
    stop = txd;
  endtask

  task automatic send_and_check(input logic [8:0] d, input bit lf, input string req);
    int w; logic [8:0] got; bit stop;
    long_fmt = lf; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    chk(tdre === 1'b0, "R4", "tdre after write", tdre, 0);
    chk(tc === 1'b0, "R4", "tc with word pending", tc, 0);
    wait_low(w, 1000 * cpt);
    rx_bits(lf, 1'b0, 0, got, stop);
    chk(got === expect_word(d, lf), req, "decoded word", got, expect_word(d, lf));
    chk(stop === 1'b1, req, "stop bit", stop, 1);
  endtask

  initial begin
    int w, len, highs;
    logic [8:0] got;
    bit stop;
    int unsigned seed;
    seed = $urandom(32'h5EED);

    nclk(5);
    rst_n = 1'b1;
    nclk(2);
    chk(txd === 1'b1, "R1", "txd after reset", txd, 1);
    chk(tdre === 1'b1, "R1", "tdre after reset", tdre, 1);
    chk(tc === 1'b1, "R1", "tc after reset", tc, 1);

    // R6: disabled transmitter holds the word and the line stays high
    long_fmt = 1'b0; wr_data = 9'h0A5; wr_en = 1'b1;
    nclk(1);
    wr_en = 1'b0;
    highs = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (txd === 1'b1) highs++;
    end
    chk(highs == 300, "R6", "high samples while disabled", highs, 300);
    chk(tdre === 1'b0, "R6", "tdre held while disabled", tdre, 0);
    chk(tc === 1'b0, "R4", "tc with held word", tc, 0);

    // R5: enabling queues a preamble of one short frame time
    tx_en = 1'b1;
    wait_low(w, 2000);
    chk(w >= 159 && w <= 162, "R5", "preamble length", w, 160);
    rx_bits(1'b0, 1'b0, 0, got, stop);
    chk(got === 9'h0A5, "R2", "word after preamble", got, 9'h0A5);
    chk(stop === 1'b1, "R2", "stop after preamble", stop, 1);
    nclk(30);
    chk(tc === 1'b1, "R4", "tc when all done", tc, 1);
    chk(tdre === 1'b1, "R4", "tdre when all done", tdre, 1);

    // R3: start bit width with bit0 = 1
    long_fmt = 1'b0; wr_data = 9'h001; wr_en = 1'b1;
    nclk(1);
    wr_en = 1'b0;
    wait_low(w, 1000);
    low_run(len);
    chk(len == 16, "R3", "start bit cycles", len, 16);
    nclk(200);

    // R2: directed format corners
    send_and_check(9'h1FF, 1'b1, "R2");
    send_and_check(9'h100, 1'b1, "R2");
    send_and_check(9'h1FF, 1'b0, "R2");
    send_and_check(9'h000, 1'b0, "R2");

    // R2: random words in both formats
    for (int k = 0; k < 24; k++) begin
      send_and_check(9'($urandom % 512), 1'($urandom % 2), "R2");
    end
    nclk(250);
    chk(tc === 1'b1, "R4", "tc after random burst", tc, 1);

    // R7: enable dropped mid frame
    long_fmt = 1'b1; wr_data = 9'h0F0; wr_en = 1'b1;
    nclk(1);
    wr_en = 1'b0;
    wait_low(w, 1000);
    nclk(20);
    tx_en = 1'b0;
    rx_bits(1'b1, 1'b0, 20, got, stop);
    chk(got === 9'h0F0, "R7", "word finished after disable", got, 9'h0F0);
    chk(stop === 1'b1, "R7", "stop finished after disable", stop, 1);
    highs = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (txd === 1'b1) highs++;
    end
    chk(highs == 200, "R7", "line high after disable", highs, 200);
    tx_en = 1'b1;
    nclk(400);

    // R9: brief break pulse, short format
    long_fmt = 1'b0;
    fork
      begin
        brk_req = 1'b1; brk_wr = 1'b1;
        nclk(1);
        brk_wr = 1'b0;
        nclk(3);
        brk_req = 1'b0;
      end
      begin
        wait_low(w, 100);
        low_run(len);
      end
    join
    chk(len == frame_ticks(1'b0), "R9", "single break zeros", len, frame_ticks(1'b0));
    highs = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (txd === 1'b1) highs++;
    end
    chk(highs == 100, "R9", "line high after break", highs, 100);
    chk(tc === 1'b1, "R4", "tc after break", tc, 1);

    // R8: held break released mid third frame, long format
    long_fmt = 1'b1;
    fork
      begin
        brk_req = 1'b1; brk_wr = 1'b1;
        nclk(1);
        brk_wr = 1'b0;
        nclk(2 * 176 + 88);
        brk_req = 1'b0;
      end
      begin
        wait_low(w, 100);
        low_run(len);
      end
    join
    chk(len == 3 * frame_ticks(1'b1), "R8", "held break zeros", len, 3 * frame_ticks(1'b1));
    nclk(100);

    // R10: break and word requested together
    long_fmt = 1'b0;
    wr_data = 9'h0B3;
    fork
      begin
        brk_req = 1'b1; brk_wr = 1'b1; wr_en = 1'b1;
        nclk(1);
        brk_wr = 1'b0; wr_en = 1'b0;
        nclk(2);
        brk_req = 1'b0;
      end
      begin
        wait_low(w, 100);
        low_run(len);
        rx_bits(1'b0, 1'b1, 0, got, stop);
      end
    join
    chk(len == frame_ticks(1'b0) + 16, "R10", "break then start bit", len, frame_ticks(1'b0) + 16);
    chk(got === 9'h0B3, "R10", "word after break", got, 9'h0B3);
    chk(stop === 1'b1, "R10", "stop after break", stop, 1);
    nclk(100);

    // R3: slower tick, one tick every three cycles
    cpt = 3;
    nclk(10);
    long_fmt = 1'b0; wr_data = 9'h001; wr_en = 1'b1;
    nclk(1);
    wr_en = 1'b0;
    wait_low(w, 3000);
    low_run(len);
    chk(len == 48, "R3", "start bit cycles at slow tick", len, 48);
    nclk(700);
    send_and_check(9'h15A, 1'b1, "R3");
    nclk(100);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule